// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable pipelined synchronous static RAM. It lets read and write cycles follow each other on consecutive clocks with no idle cycle on the data bus. Address, command and chip-select inputs are registered on the rising clock edge. Read data appears two active edges after its command. Write data and its lane strobes are taken two active edges after the write command, in the same pipeline slot where a read would have returned data, so the shared bus never needs a turnaround gap.

A load cycle takes a new external address. An advance cycle repeats the previous operation type (read, write or deselect) at the next address of a four-beat burst, in linear or interleaved order. Captured write data waits one more edge in a pending register before it enters the array. A bypass path merges that pending data, lane by lane, into a read of the same word. An active-high stall input freezes every register. The bidirectional bus is split into a data input, a data output and an output-enable flag.

Top module: `zt_sram`

## Requirements
- R1: A load cycle is selected only when sel_a_n=0, sel_b=1 and sel_c_n=0; any other combination is a deselect, and two active edges later dout_en stays 0.
- R2: A selected load cycle (adv=0) with we_n=1 is a read of addr; its word drives dout with dout_en=1 after the second active edge following the command.
- R3: An advance cycle (adv=1) ignores the selects, we_n and addr, and repeats the previous cycle's operation type; an advance after a deselect is again a deselect.
- R4: Beat n (0..3) of a burst keeps the upper address bits of the loaded address. Its two low bits are (start+n) mod 4 when burst_ilv=0, and start XOR n when burst_ilv=1.
- R5: For a write, din and bw_n are sampled at the second active edge after the command. Lane i is din[9i+8:9i]; it is written only when bw_n[i]=0. With all bw_n bits high the word is unchanged.
- R6: A read issued on the cycle right after a write to the same address returns the new data, merged by lane with the old word.
- R7: While clk_en_n=1, all inputs are ignored and dout and dout_en keep their values.
- R8: dout_en is 1 only when oe_n=0 and the output register holds read data; dout is all zeros while dout_en=0. oe_n acts without a clock.
- R9: After reset, dout_en is 0 and every word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en_n | input | 1 | Stall: 1 freezes every register |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| adv | input | 1 | 0 loads a new address, 1 advances the burst |
| we_n | input | 1 | 0 write, 1 read on a load cycle |
| burst_ilv | input | 1 | Burst order: 0 linear, 1 interleaved |
| addr | input | ADDR_W | Word address |
| bw_n | input | LANES | Lane write strobes, active low, sampled with data |
| din | input | LANES*LANE_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | LANES*LANE_W | Read data, zero when not enabled |
| dout_en | output | 1 | Output bus is driven |

## Verification
In a single active edge, the array can commit a pending write while a read in the second stage fetches the same word. That collision is what the bypass path has to resolve. The bench provokes it with directed write-then-read pairs to one address using partial lane strobes, and it also arises from dense random traffic over a small address space. Each result is judged against a behavioural model that applies every write at its data edge and resolves every read from that model at its own output edge, with no notion of the pending register.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  typedef enum logic [1:0] {
    OP_DS = 2'd0,
    OP_RD = 2'd1,
    OP_WR = 2'd2
  } zt_op_e;

  // low two address bits of burst beat 'step' from 'start'
  function automatic logic [1:0] burst_lsb(input logic [1:0] start,
                                           input logic [1:0] step,
                                           input logic       ilv);
    burst_lsb = ilv ? (start ^ step) : (start + step);
  endfunction

endpackage

// File: rtl/zt_cmd_stage.sv
module zt_cmd_stage
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              adv,
  input  logic              we_n,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  output zt_op_e            s1_op,
  output logic [ADDR_W-1:0] s1_addr
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic [1:0]        beat_nx;
  logic              selected;
  zt_op_e            op_nx;
  logic [ADDR_W-1:0] addr_nx;

  assign selected = !sel_a_n && sel_b && !sel_c_n;
  assign beat_nx  = adv ? beat_q + 2'd1 : 2'd0;

  always_comb begin
    if (!adv) begin
      op_nx   = selected ? (we_n ? OP_RD : OP_WR) : OP_DS;
      addr_nx = addr;
    end else begin
      op_nx   = s1_op;
      addr_nx = {base_q[ADDR_W-1:2], burst_lsb(base_q[1:0], beat_nx, burst_ilv)};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op   <= OP_DS;
      s1_addr <= '0;
      base_q  <= '0;
      beat_q  <= '0;
    end else if (!hold) begin
      s1_op   <= op_nx;
      s1_addr <= addr_nx;
      beat_q  <= beat_nx;
      if (!adv) base_q <= addr;
    end
  end
endmodule

// File: rtl/zt_wr_capture.sv
module zt_wr_capture
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  zt_op_e            s2_op,
  input  logic [ADDR_W-1:0] s2_addr,
  input  logic [DW-1:0]     din,
  input  logic [LANES-1:0]  bw_n,
  output logic              pend_vld,
  output logic [ADDR_W-1:0] pend_addr,
  output logic [DW-1:0]     pend_data,
  output logic [LANES-1:0]  pend_mask
);
  logic wr_take;
  assign wr_take = (s2_op == OP_WR) && (bw_n != {LANES{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
      pend_data <= '0;
      pend_mask <= '0;
    end else if (!hold) begin
      pend_vld  <= wr_take;
      pend_addr <= s2_addr;
      pend_data <= din;
      pend_mask <= ~bw_n;
    end
  end
endmodule

// File: rtl/zt_mem_core.sv
module zt_mem_core #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic              pend_vld,
  input  logic [ADDR_W-1:0] pend_addr,
  input  logic [DW-1:0]     pend_data,
  input  logic [LANES-1:0]  pend_mask,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              bypass_hit,
  output logic [DW-1:0]     rd_data_q,
  output logic              rd_vld_q
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_word;
  logic [DW-1:0] wr_word;

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0]    old_w,
                                               input logic [DW-1:0]    new_w,
                                               input logic [LANES-1:0] keep_new);
    logic [DW-1:0] res;
    res = old_w;
    for (int i = 0; i < LANES; i++)
      if (keep_new[i]) res[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
    return res;
  endfunction

  assign bypass_hit = pend_vld && (pend_addr == rd_addr);
  assign wr_word    = lane_merge(mem[pend_addr], pend_data, pend_mask);
  assign rd_word    = bypass_hit ? lane_merge(mem[rd_addr], pend_data, pend_mask)
                                 : mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < DEPTH; w++) mem[w] <= '0;
    end else if (!hold && pend_vld) begin
      mem[pend_addr] <= wr_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data_q <= '0;
      rd_vld_q  <= 1'b0;
    end else if (!hold) begin
      rd_vld_q <= rd_req;
      if (rd_req) rd_data_q <= rd_word;
    end
  end
endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en_n,
  input  logic              sel_a_n,
  input  logic              sel_b,
  input  logic              sel_c_n,
  input  logic              adv,
  input  logic              we_n,
  input  logic              burst_ilv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  bw_n,
  input  logic [DW-1:0]     din,
  input  logic              oe_n,
  output logic [DW-1:0]     dout,
  output logic              dout_en
);
  zt_op_e            s1_op, s2_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic              pend_vld;
  logic [ADDR_W-1:0] pend_addr;
  logic [DW-1:0]     pend_data;
  logic [LANES-1:0]  pend_mask;
  logic              bypass_hit;
  logic [DW-1:0]     rd_data_q;
  logic              rd_vld_q;
  logic              s2_is_rd;
  logic              s2_is_wr;

  zt_cmd_stage #(.ADDR_W(ADDR_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .hold(clk_en_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .adv(adv), .we_n(we_n), .burst_ilv(burst_ilv), .addr(addr),
    .s1_op(s1_op), .s1_addr(s1_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_op   <= OP_DS;
      s2_addr <= '0;
    end else if (!clk_en_n) begin
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
    end
  end

  assign s2_is_rd = (s2_op == OP_RD);
  assign s2_is_wr = (s2_op == OP_WR);

  zt_wr_capture #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wcap (
    .clk(clk), .rst_n(rst_n), .hold(clk_en_n),
    .s2_op(s2_op), .s2_addr(s2_addr), .din(din), .bw_n(bw_n),
    .pend_vld(pend_vld), .pend_addr(pend_addr),
    .pend_data(pend_data), .pend_mask(pend_mask)
  );

  zt_mem_core #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .hold(clk_en_n),
    .pend_vld(pend_vld), .pend_addr(pend_addr),
    .pend_data(pend_data), .pend_mask(pend_mask),
    .rd_req(s2_is_rd), .rd_addr(s2_addr),
    .bypass_hit(bypass_hit), .rd_data_q(rd_data_q), .rd_vld_q(rd_vld_q)
  );

  assign dout_en = !oe_n && rd_vld_q;
  assign dout    = dout_en ? rd_data_q : '0;
endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk
  import zt_sram_pkg::*;
#(
  parameter int DW = 36
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clk_en_n,
  input logic          adv,
  input logic          oe_n,
  input logic          dout_en,
  input logic [DW-1:0] dout,
  input zt_op_e        s1_op,
  input logic          s2_is_rd,
  input logic          s2_is_wr,
  input logic          rd_vld_q,
  input logic [DW-1:0] rd_data_q
);
  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(rd_vld_q) && $stable(rd_data_q))) else $error("stall"); // R7

  AST_READ_REACHES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && s2_is_rd) |=> rd_vld_q) else $error("read latency"); // R2

  AST_WRITE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && s2_is_wr) |=> !rd_vld_q) else $error("write drove bus"); // R5

  AST_DESEL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && adv && s1_op == OP_DS) |=> (s1_op == OP_DS)) else $error("desel cont"); // R3

  AST_OE_GATES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dout_en) else $error("oe"); // R8

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> (dout == '0)) else $error("idle bus"); // R8
endmodule

bind zt_sram zt_sram_chk #(.DW(LANES * LANE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .adv(adv), .oe_n(oe_n),
  .dout_en(dout_en), .dout(dout), .s1_op(s1_op), .s2_is_rd(s2_is_rd),
  .s2_is_wr(s2_is_wr), .rd_vld_q(rd_vld_q), .rd_data_q(rd_data_q)
);

// File: tb/zt_sram_bench.sv
module zt_sram_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clk_en_n = 1'b0, sel_a_n = 1'b1, sel_b = 1'b0, sel_c_n = 1'b1;
  logic adv = 1'b0, we_n = 1'b1, burst_ilv = 1'b0, oe_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [NL-1:0] bw_n = '1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic          dout_en;

  always #(CLK_PERIOD/2) clk = ~clk;

  zt_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_zt_sram (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .sel_a_n(sel_a_n),
    .sel_b(sel_b), .sel_c_n(sel_c_n), .adv(adv), .we_n(we_n),
    .burst_ilv(burst_ilv), .addr(addr), .bw_n(bw_n), .din(din),
    .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
  );

  // reference model: 0 deselect, 1 read, 2 write
  typedef struct { int kind; int a; } cmd_t;
  cmd_t          pipe_q[$];
  logic [DW-1:0] ref_mem [1 << AW];
  int            m_last = 0, m_base = 0, m_beat = 0;
  logic          exp_vld = 1'b0;
  logic [DW-1:0] exp_data = '0;
  int            n_tests = 0, n_fail = 0;
  string         tag = "R9";
  bit            done = 0;

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic check_bit(input string t, input logic act, input logic ex);
    n_tests++;
    if (act !== ex) begin
      n_fail++;
      $display("FAIL %s dout_en actual=%0b expected=%0b", t, act, ex);
    end
  endtask

  task automatic check_word(input string t, input logic [DW-1:0] act, input logic [DW-1:0] ex);
    n_tests++;
    if (act !== ex) begin
      n_fail++;
      $display("FAIL %s dout actual=%h expected=%h", t, act, ex);
    end
  endtask

  task automatic model_edge();
    cmd_t c, old;
    int   sel;
    if (clk_en_n) return;
    sel = (!sel_a_n && sel_b && !sel_c_n) ? 1 : 0;
    if (!adv) begin
      c.kind = sel ? (we_n ? 1 : 2) : 0;
      m_base = addr; m_beat = 0; c.a = addr;
    end else begin
      c.kind = m_last;
      m_beat = (m_beat + 1) % 4;
      if (burst_ilv) c.a = (m_base & ~3) | ((m_base & 3) ^ m_beat);
      else           c.a = (m_base & ~3) | (((m_base & 3) + m_beat) % 4);
    end
    m_last = c.kind;
    exp_vld = 1'b0;
    if (pipe_q.size() == 2) begin
      old = pipe_q.pop_front();
      if (old.kind == 2) begin
        for (int i = 0; i < NL; i++)
          if (!bw_n[i]) ref_mem[old.a][i*LW +: LW] = din[i*LW +: LW];
      end else if (old.kind == 1) begin
        exp_vld = 1'b1;
        exp_data = ref_mem[old.a];
      end
    end
    pipe_q.push_back(c);
  endtask

  task automatic tick();
    @(posedge clk);
    #1 model_edge();
    @(negedge clk);
    check_bit(tag, dout_en, !oe_n && exp_vld);
    if (!oe_n && exp_vld) check_word(tag, dout, exp_data);
    else                  check_word(tag, dout, '0);
  endtask

  task automatic load(input bit sel, input bit wr, input int a);
    adv = 1'b0; sel_a_n = !sel; sel_b = sel; sel_c_n = !sel;
    we_n = !wr; addr = a[AW-1:0];
    tick();
  endtask

  task automatic advance();
    adv = 1'b1; sel_a_n = 1'b1; sel_b = 1'b0; we_n = !we_n; addr = ~addr;
    tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int w = 0; w < (1 << AW); w++) ref_mem[w] = '0;
    repeat (3) @(negedge clk);
    check_bit("R9", dout_en, 1'b0);
    rst_n = 1'b1;

    // R9: reads after reset return zero
    tag = "R9";
    load(1, 0, 5); load(1, 0, 40); load(0, 0, 0); load(0, 0, 0);

    // R4/R5: linear write burst from 6 with full strobes, data lagging two edges
    tag = "R4"; burst_ilv = 1'b0; bw_n = '0;
    din = 36'h1_1111_1111; load(1, 1, 6);
    din = 36'h2_2222_2222; advance();
    din = 36'h3_3333_3333; advance();
    din = 36'h4_4444_4444; advance();
    din = 36'h5_5555_5555; load(0, 0, 0);
    din = '0; load(0, 0, 0);
    // R4: interleaved read burst from 6 (order 6,7,4,5)
    burst_ilv = 1'b1;
    load(1, 0, 6); advance(); advance(); advance();
    load(0, 0, 0); load(0, 0, 0);
    // R4: interleaved from 5 (5,4,7,6), linear from 7 (7,4,5,6)
    load(1, 0, 5); advance(); advance(); advance();
    burst_ilv = 1'b0;
    load(1, 0, 7); advance(); advance(); advance();
    load(0, 0, 0); load(0, 0, 0);

    // R6: write then immediate read of the same word, partial lanes
    tag = "R6";
    load(1, 1, 6); load(1, 0, 6);
    bw_n = 4'b1010; din = 36'hA_BCDE_F012; load(1, 1, 7);
    bw_n = 4'b0110; din = 36'h9_8765_4321; load(1, 0, 7);
    bw_n = '1; load(1, 0, 7); load(0, 0, 0); load(0, 0, 0);

    // R5: all strobes high aborts the write
    tag = "R5";
    load(1, 1, 9); load(0, 0, 0);
    bw_n = '1; din = '1; load(1, 0, 9); load(0, 0, 0); load(0, 0, 0);

    // R1: each select alone deselects, R3: advance after deselect
    tag = "R1";
    adv = 0; we_n = 1; addr = 6;
    sel_a_n = 1; sel_b = 1; sel_c_n = 0; tick();
    sel_a_n = 0; sel_b = 0; sel_c_n = 0; tick();
    sel_a_n = 0; sel_b = 1; sel_c_n = 1; tick();
    tag = "R3";
    advance(); advance(); load(1, 0, 4); advance(); advance(); advance();
    load(0, 0, 0); load(0, 0, 0);

    // R7: stall in the middle of a read burst
    tag = "R7";
    load(1, 0, 6); advance();
    clk_en_n = 1; tick(); tick(); addr = 3; tick();
    clk_en_n = 0; advance(); advance(); load(0, 0, 0); load(0, 0, 0);

    // R8: output enable gates the bus
    tag = "R8";
    load(1, 0, 7); load(1, 0, 6); oe_n = 1; load(0, 0, 0);
    oe_n = 0; load(0, 0, 0); load(0, 0, 0);

    // R2: random traffic over a small address space
    tag = "R2";
    for (int k = 0; k < 4000; k++) begin
      if (k == 2000) burst_ilv = 1'b1;
      clk_en_n = ($urandom % 8) == 0;
      oe_n     = ($urandom % 12) == 0;
      adv      = ($urandom % 3) == 0;
      sel_a_n  = ($urandom % 10) == 0;
      sel_b    = ($urandom % 10) != 0;
      sel_c_n  = ($urandom % 10) == 0;
      we_n     = $urandom % 2;
      addr     = $urandom % 16;
      bw_n     = (($urandom % 3) == 0) ? NL'($urandom) : '0;
      din      = {$urandom, $urandom};
      tick();
    end
    finish_run();
  end
endmodule